// File: doc/BRIEF.md
# Translation-Favoring Victim Selector

This block decides which way of one cache set gets evicted when a line must be filled. Every way carries a flag saying whether the line holds page-table entries written by the page walker or ordinary data. Eviction is steered away from the page-table lines: most replacements look only at data lines. A small pseudo-random share of replacements, and any set that holds nothing but page-table lines, fall back to all ways. Within whichever group is eligible, the least recently used way is evicted.

The block keeps the valid bits, the translation flags and the recency order of its set. Lookups that hit refresh the recency order. Fills also write the valid bit and the translation flag of the chosen way. A per-context mask turns the protection off for contexts that should not get it. A test input overrides the random draw, so that either policy branch can be reached on purpose.

Requests use a valid-only stream interface. The block accepts a request in every cycle that `req_valid` is high and never applies back-pressure. The result follows exactly one cycle later and cannot be stalled.

Top module: `tfc_victim_sel`

## Requirements
- R1: A fill request (`req_op`=1) accepted in cycle t makes `vic_valid` high in cycle t+1, with the chosen way on `vic_way`. A hit request (`req_op`=0), or an idle cycle, leaves `vic_valid` low in the following cycle.
- R2: If any way of the set is invalid, a fill takes the lowest-numbered invalid way, whatever the flags, the context or the draw.
- R3: Within the eligible group, the victim is the least recently used way. Every accepted hit (way `req_way`) and every fill (the chosen way) makes that way the most recently used. After reset, way 0 counts as the most recent and way WAYS-1 as the least recent.
- R4: A fill marks its way valid and sets that way's translation flag to `req_walk` (1 = page-walker fill, 0 = data fill). `way_valid_o` and `way_xlat_o` show bit i for way i from the cycle after the fill.
- R5: When all ways are valid, at least one way holds data, the requesting context's bit in `ctx_favor_en` is set and the draw is at least 10, the victim is the least recently used data way.
- R6: When all ways are valid and the draw is below 10, the victim is the least recently used way of the whole set.
- R7: When every way is valid and flagged as translation, the victim is the least recently used way of the whole set, for any draw.
- R8: When the bit of `ctx_favor_en` indexed by `req_ctx` is clear, a replacement considers all ways.
- R9: The draw is the low 10 bits of a 16-bit shift register. It resets to 0xACE1 and steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps once per replacement, meaning a fill with no invalid way, and only then. Each replacement uses the value held before its own step.
- R10: While `test_force` is high, `test_draw` replaces the draw. The shift register still steps once per replacement.
- R11: After reset all ways are invalid, no translation flag is set, and `vic_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = hit lookup, 1 = fill |
| req_walk | input | 1 | Fill comes from the page walker |
| req_way | input | $clog2(WAYS) | Way that hit |
| req_ctx | input | $clog2(CTXS) | Context of the request |
| ctx_favor_en | input | CTXS | Per-context enable for protecting translation lines |
| test_force | input | 1 | Use `test_draw` instead of the random draw |
| test_draw | input | DRAW_BITS | Forced draw value |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | $clog2(WAYS) | Victim way |
| way_valid_o | output | WAYS | Valid bit of each way |
| way_xlat_o | output | WAYS | Translation flag of each way |

## Verification
The bench builds the block with four ways and four contexts. Sets made up entirely of translation lines then take only a few fills to reach. Recency corner cases, such as the oldest way being a protected line, come up often in random traffic. The draw width and threshold stay at their defaults, so the free-running register follows the required sequence. The forced draw covers both sides of the threshold, and a long unforced run exercises the natural draws.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic {
    OP_HIT  = 1'b0,
    OP_FILL = 1'b1
  } tfc_op_e;
endpackage

// File: rtl/tfc_lfsr.sv
// Fibonacci shift register; steps only when adv is high.
module tfc_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   s_q <= SEED;
    else if (adv) s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
  end

  assign state = s_q;
endmodule

// File: rtl/tfc_age_lru.sv
// Per-way age counters forming a permutation; age 0 is most recent.
module tfc_age_lru #(
  parameter int WAYS = 8,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch,
  input  logic [WW-1:0]   touch_way,
  input  logic [WAYS-1:0] cand,
  output logic [WW-1:0]   oldest
);
  logic [WW-1:0] age_q [WAYS];
  logic [WW-1:0] touched_age;

  assign touched_age = age_q[touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= WW'(i);
    end else if (touch) begin
      for (int i = 0; i < WAYS; i++) begin
        if (WW'(i) == touch_way)        age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic          found;
    logic [WW-1:0] best_age;
    oldest   = '0;
    best_age = '0;
    found    = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!found || age_q[i] > best_age)) begin
        found    = 1'b1;
        best_age = age_q[i];
        oldest   = WW'(i);
      end
    end
  end
endmodule

// File: rtl/tfc_cand_mask.sv
// Finds the first invalid way and builds the eligible group for replacement.
module tfc_cand_mask #(
  parameter int WAYS = 8,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] valid,
  input  logic [WAYS-1:0] xlat,
  input  logic            widen,
  output logic            has_inv,
  output logic [WW-1:0]   inv_way,
  output logic [WAYS-1:0] cand
);
  logic [WAYS-1:0] data_ways;

  assign data_ways = valid & ~xlat;

  always_comb begin
    has_inv = 1'b0;
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        has_inv = 1'b1;
        inv_way = WW'(i);
      end
    end
  end

  assign cand = (widen || data_ways == '0) ? {WAYS{1'b1}} : data_ways;
endmodule

// File: rtl/tfc_victim_sel.sv
module tfc_victim_sel #(
  parameter int WAYS       = 8,
  parameter int CTXS       = 4,
  parameter int LFSR_W     = 16,
  parameter int DRAW_BITS  = 10,
  parameter int DRAW_LIMIT = 10,
  localparam int WW        = $clog2(WAYS),
  localparam int CW        = $clog2(CTXS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_op,
  input  logic                 req_walk,
  input  logic [WW-1:0]        req_way,
  input  logic [CW-1:0]        req_ctx,
  input  logic [CTXS-1:0]      ctx_favor_en,
  input  logic                 test_force,
  input  logic [DRAW_BITS-1:0] test_draw,
  output logic                 vic_valid,
  output logic [WW-1:0]        vic_way,
  output logic [WAYS-1:0]      way_valid_o,
  output logic [WAYS-1:0]      way_xlat_o
);
  import tfc_pkg::*;

  localparam logic [DRAW_BITS-1:0] LIMIT_V = DRAW_BITS'(DRAW_LIMIT);

  logic [WAYS-1:0]      valid_q, xlat_q;
  logic [LFSR_W-1:0]    lfsr_s;
  logic [DRAW_BITS-1:0] draw;
  logic                 favor_en, widen, is_fill, replace;
  logic                 has_inv;
  logic [WW-1:0]        inv_way, old_way, pick_way, touch_way;
  logic [WAYS-1:0]      cand;

  assign is_fill  = req_valid && (tfc_op_e'(req_op) == OP_FILL);
  assign draw     = test_force ? test_draw : lfsr_s[DRAW_BITS-1:0];
  assign favor_en = ctx_favor_en[req_ctx];
  assign widen    = !favor_en || (draw < LIMIT_V);
  assign replace  = is_fill && !has_inv;

  tfc_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(replace), .state(lfsr_s)
  );

  tfc_cand_mask #(.WAYS(WAYS)) u_cand (
    .valid(valid_q), .xlat(xlat_q), .widen(widen),
    .has_inv(has_inv), .inv_way(inv_way), .cand(cand)
  );

  assign pick_way  = has_inv ? inv_way : old_way;
  assign touch_way = is_fill ? pick_way : req_way;

  tfc_age_lru #(.WAYS(WAYS)) u_age (
    .clk(clk), .rst_n(rst_n), .touch(req_valid), .touch_way(touch_way),
    .cand(cand), .oldest(old_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      xlat_q    <= '0;
      vic_valid <= 1'b0;
      vic_way   <= '0;
    end else begin
      vic_valid <= is_fill;
      if (is_fill) begin
        vic_way           <= pick_way;
        valid_q[pick_way] <= 1'b1;
        xlat_q[pick_way]  <= req_walk;
      end
    end
  end

  assign way_valid_o = valid_q;
  assign way_xlat_o  = xlat_q;
endmodule

// File: rtl/tfc_victim_sel_chk.sv
module tfc_victim_sel_chk #(
  parameter int WAYS      = 8,
  parameter int DRAW_BITS = 10,
  parameter int DRAW_LIMIT = 10,
  localparam int WW       = $clog2(WAYS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_op,
  input logic                 favor_en,
  input logic [DRAW_BITS-1:0] draw,
  input logic                 vic_valid,
  input logic [WW-1:0]        vic_way,
  input logic [WAYS-1:0]      way_valid_o,
  input logic [WAYS-1:0]      way_xlat_o
);
  logic [WAYS-1:0] p_valid, p_xlat;
  logic            p_protect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid   <= '0;
      p_xlat    <= '0;
      p_protect <= 1'b0;
    end else begin
      p_valid   <= way_valid_o;
      p_xlat    <= way_xlat_o;
      p_protect <= favor_en && (int'(draw) >= DRAW_LIMIT);
    end
  end

  a_r1_fill_result: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op) |=> vic_valid);
  a_r1_hit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_op) |=> !vic_valid);
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !(&p_valid)) |-> !p_valid[vic_way]);
  a_r5_data_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && (&p_valid) && ((p_valid & ~p_xlat) != '0) && p_protect)
      |-> !p_xlat[vic_way]);
  a_r4_victim_valid: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> way_valid_o[vic_way]);
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((way_valid_o & $past(way_valid_o)) == $past(way_valid_o)));
  a_r4_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (way_xlat_o & ~way_valid_o) == '0);
endmodule

bind tfc_victim_sel tfc_victim_sel_chk #(
  .WAYS(WAYS), .DRAW_BITS(DRAW_BITS), .DRAW_LIMIT(DRAW_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .favor_en(favor_en), .draw(draw), .vic_valid(vic_valid),
  .vic_way(vic_way), .way_valid_o(way_valid_o), .way_xlat_o(way_xlat_o)
);

// File: tb/tfc_victim_sel_tb.sv
module tfc_victim_sel_tb;
  localparam int NW = 4;
  localparam int NC = 4;
  localparam int DB = 10;
  localparam int DL = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_op, req_walk, test_force;
  logic [1:0]    req_way, req_ctx;
  logic [NC-1:0] ctx_favor_en;
  logic [DB-1:0] test_draw;
  logic          vic_valid;
  logic [1:0]    vic_way;
  logic [NW-1:0] way_valid_o, way_xlat_o;

  tfc_victim_sel #(.WAYS(NW), .CTXS(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_walk(req_walk), .req_way(req_way), .req_ctx(req_ctx),
    .ctx_favor_en(ctx_favor_en), .test_force(test_force), .test_draw(test_draw),
    .vic_valid(vic_valid), .vic_way(vic_way),
    .way_valid_o(way_valid_o), .way_xlat_o(way_xlat_o)
  );

  int m_age[NW];
  bit m_val[NW];
  bit m_x[NW];
  int m_lfsr;
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic int lfsr_next(int l);
    int b;
    b = ((l >> 15) ^ (l >> 13) ^ (l >> 12) ^ (l >> 10)) & 1;
    return ((l << 1) | b) & 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int mask_of(bit b[NW]);
    int m = 0;
    for (int i = 0; i < NW; i++) if (b[i]) m |= (1 << i);
    return m;
  endfunction

  // One request cycle: drive at negedge, update the model, compare at next negedge.
  task automatic step(bit v, bit op, int way, bit walk, int ctx, bit frc, int drw);
    bit    exp_vv;
    int    exp_vw = 0;
    int    tw = way;
    string tag = "R1";
    req_valid = v; req_op = op; req_way = way[1:0]; req_walk = walk;
    req_ctx = ctx[1:0]; test_force = frc; test_draw = drw[DB-1:0];
    exp_vv = v && op;
    if (v) begin
      if (op) begin
        int inv = -1;
        for (int i = 0; i < NW; i++) if (!m_val[i] && inv < 0) inv = i;
        if (inv >= 0) begin
          tw = inv; tag = "R2";
        end else begin
          int  d = frc ? drw : (m_lfsr & 1023);
          bit  allx = 1;
          bit  widen;
          int  best = -1;
          for (int i = 0; i < NW; i++) if (!m_x[i]) allx = 0;
          widen = allx || !ctx_favor_en[ctx] || d < DL;
          if (allx) tag = "R7";
          else if (!ctx_favor_en[ctx]) tag = "R8";
          else if (d < DL) tag = frc ? "R10/R6" : "R9/R6";
          else tag = frc ? "R10/R5" : "R9/R5";
          for (int i = 0; i < NW; i++)
            if ((widen || !m_x[i]) && (best < 0 || m_age[i] > m_age[best])) best = i;
          tw = best;
          m_lfsr = lfsr_next(m_lfsr);
        end
        exp_vw = tw;
        m_val[tw] = 1;
        m_x[tw] = walk;
      end
      begin
        int a = m_age[tw];
        for (int i = 0; i < NW; i++) begin
          if (i == tw) m_age[i] = 0;
          else if (m_age[i] < a) m_age[i]++;
        end
      end
    end
    @(negedge clk);
    chk(vic_valid == exp_vv, "R1", "vic_valid", vic_valid, exp_vv);
    if (exp_vv) chk(int'(vic_way) == exp_vw, {tag, " R3"}, "vic_way", vic_way, exp_vw);
    chk(int'(way_valid_o) == mask_of(m_val), "R4", "way_valid_o", way_valid_o, mask_of(m_val));
    chk(int'(way_xlat_o) == mask_of(m_x), "R4", "way_xlat_o", way_xlat_o, mask_of(m_x));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_walk = 0; req_way = 0;
    req_ctx = 0; ctx_favor_en = '1; test_force = 0; test_draw = 0;
    for (int i = 0; i < NW; i++) begin m_age[i] = i; m_val[i] = 0; m_x[i] = 0; end
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(vic_valid == 1'b0, "R11", "vic_valid", vic_valid, 0);
    chk(way_valid_o == '0, "R11", "way_valid_o", way_valid_o, 0);
    chk(way_xlat_o == '0, "R11", "way_xlat_o", way_xlat_o, 0);

    // R2: data fills land in invalid ways 0..3 in order
    for (int i = 0; i < NW; i++) step(1, 1, 0, 0, 0, 1, 1023);
    // R4: walker fill replaces LRU data way and flags it
    step(1, 1, 0, 1, 0, 1, 1023);
    // R3: hits reorder recency, leaving the translation line oldest
    step(1, 0, 1, 0, 0, 1, 1023);
    step(1, 0, 2, 0, 0, 1, 1023);
    step(1, 0, 3, 0, 0, 1, 1023);
    step(0, 0, 0, 0, 0, 1, 1023);
    // R5: protected replacement skips the oldest (translation) way
    step(1, 1, 0, 0, 0, 1, 10);
    // R6/R10: forced draw below threshold may take the translation way
    step(1, 0, 1, 0, 0, 1, 1023);
    step(1, 1, 0, 0, 0, 1, 9);
    // R7: make every way a translation line, then replace with protection on
    for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 0, 1, 1023);
    step(1, 1, 0, 1, 0, 1, 1023);
    // R8: context with cleared bit considers all ways
    step(1, 1, 0, 0, 0, 1, 1023);
    ctx_favor_en = 4'b1101;
    step(1, 1, 0, 0, 1, 1, 1023);
    step(1, 1, 0, 0, 0, 1, 1023);
    // R9: free-running draw over long random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (n % 500 == 0) ctx_favor_en = NC'($urandom_range(0, 15));
      step(r < 85, r < 45, $urandom_range(0, NW - 1), r[0] ^ r[3],
           $urandom_range(0, NC - 1), 0, 0);
    end
    // R10: forced draws around the threshold, register keeps stepping
    for (int n = 0; n < 400; n++)
      step(1, 1, 0, n[1], 0, 1, (n % 3 == 0) ? 9 : ((n % 3 == 1) ? 10 : 0));
    ctx_favor_en = '1;
    for (int n = 0; n < 200; n++) step(1, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule